// File: doc/BRIEF.md
# Configuration Frame Scrubber

This block keeps a modelled configuration store free of bit upsets while the logic that depends on it keeps running. The store is organised as frames of equal size. A read-only golden image, computed from the word index, holds the intended contents. After reset the controller writes the whole golden image into the store. It then sweeps the frames in a loop that never ends. On each visit it reads a frame back word by word, compares each word with the golden word, and then rewrites the whole frame from the golden image.

A frame that held at least one wrong word is reported with a one-cycle pulse, the frame index, and a saturating upset counter. A separate read port gives the user logic the stored word in the same cycle, with no stall. A test port flips chosen bits of one stored word, so upsets can be created on demand. A reload input restarts the full load from frame 0 at any time and keeps the counter.

Top module: `cfg_scrubber`

## Requirements
- R1: While reset is held, `init_done_o`, `repaired_o`, `repaired_frame_o` and `upset_count_o` are all 0.
- R2: After reset is released, the controller writes one word per clock edge: frame 0 word 0 first, then every word of every frame in ascending order. `init_done_o` rises after exactly NUM_FRAMES*FRAME_WORDS edges. Every stored word then equals the golden word `(0xA5C3 ^ frame*0x0451 ^ word*0x1203) mod 2^WORD_W`.
- R3: Once `init_done_o` is high, frames are visited in ascending order and wrap from the last frame to frame 0. Each visit is FRAME_WORDS read cycles followed by FRAME_WORDS write cycles. The first cycle with `init_done_o` high reads frame 0, word 0.
- R4: Suppose a word of frame f differs from its golden value when it is read. Then `repaired_o` is high in the cycle after the last write cycle of that visit, `repaired_frame_o` shows f, and the word is golden again.
- R5: Several wrong words in one frame on one visit give one pulse and raise the counter by one.
- R6: The counter rises by one on each pulse and stays at 2^CNT_W-1 once it reaches that value. The counter and `repaired_frame_o` do not change between pulses.
- R7: Every write takes its data from the golden image. Suppose a flip lands on a word after that word was read but before it is written back on the same visit. Then the word is restored at the write with no pulse.
- R8: Suppose a flip lands on a word after that word has been written back on a visit. Then the word is golden again no later than 2*NUM_FRAMES*FRAME_WORDS cycles after the flip, and the next visit reports that frame.
- R9: `usr_data_o` returns the stored word at `usr_addr_i` in the same cycle. It keeps doing so during loading and scrubbing.
- R10: When `reload_i` is high at an edge, `init_done_o` is low after that edge. The full load restarts from frame 0, and `init_done_o` rises again NUM_FRAMES*FRAME_WORDS edges later. The counter and `repaired_frame_o` keep their values. Pending flips are overwritten with no pulse.
- R11: `inj_en_i` XORs `inj_mask_i` into the word at address `{frame, word}` (frame in the upper bits) at the clock edge. If the scrubber writes the same word at the same edge, the golden write wins.
- R12: `repaired_o` is never high in two consecutive cycles.

NUM_FRAMES and FRAME_WORDS are powers of two and at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reload_i | input | 1 | Restart the full load from frame 0 |
| inj_en_i | input | 1 | Apply the test bit-flip this edge |
| inj_addr_i | input | ADDR_W | Word address for the flip, {frame, word} |
| inj_mask_i | input | WORD_W | Bits to invert |
| usr_addr_i | input | ADDR_W | User read address, {frame, word} |
| usr_data_o | output | WORD_W | Stored word at the user address |
| init_done_o | output | 1 | High once the full load has finished |
| repaired_o | output | 1 | One-cycle pulse: the visited frame held an upset |
| repaired_frame_o | output | FRAME_W | Index of the last reported frame |
| upset_count_o | output | CNT_W | Saturating count of reported frames |

## Verification
The bound checker watches properties that hold on every cycle:
- the pulse is one cycle wide;
- the counter holds between pulses, and rises by one or stays saturated on a pulse;
- the frame output holds between pulses;
- no pulse occurs while loading;
- a reload is followed by a drop of `init_done_o`, and `init_done_o` drops for no other reason.

Some behaviour depends on where a flip lands within a visit, and only the bench's timed scenarios can show it. This covers detection on the following visit, silent repair between read and write, the golden write winning over a flip on the same edge, and repair within one full sweep after a late flip. The scenarios also check the frame order, the pulse timing, and the preserved counter across a reload.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } scrub_state_e;

    // Golden word for a frame/word pair; callers truncate to their word width.
    function automatic logic [63:0] golden_value(input int unsigned frame,
                                                 input int unsigned word);
        return 64'hA5C3 ^ (64'(frame) * 64'h0451) ^ (64'(word) * 64'h1203);
    endfunction

endpackage

// File: rtl/scrub_golden.sv
module scrub_golden #(
    parameter int NUM_FRAMES  = 8,
    parameter int FRAME_WORDS = 16,
    parameter int WORD_W      = 32,
    localparam int DEPTH      = NUM_FRAMES * FRAME_WORDS,
    localparam int ADDR_W     = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [WORD_W-1:0] data_o
);
    import scrub_pkg::*;

    logic [WORD_W-1:0] image [DEPTH];

    // Read-only image, one entry per word, derived from the index.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign image[i] = WORD_W'(golden_value(i / FRAME_WORDS, i % FRAME_WORDS));
    end

    assign data_o = image[addr_i];

endmodule

// File: rtl/scrub_cfg_mem.sv
module scrub_cfg_mem #(
    parameter int DEPTH  = 128,
    parameter int WORD_W = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              inj_en_i,
    input  logic [ADDR_W-1:0] inj_addr_i,
    input  logic [WORD_W-1:0] inj_mask_i,
    input  logic [ADDR_W-1:0] scrub_addr_i,
    output logic [WORD_W-1:0] scrub_data_o,
    input  logic [ADDR_W-1:0] usr_addr_i,
    output logic [WORD_W-1:0] usr_data_o
);
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (inj_en_i) begin
            mem_d[inj_addr_i] = mem_q[inj_addr_i] ^ inj_mask_i;
        end
        // A scrub write on the same word overrides a flip in the same cycle.
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // Two independent read ports: the scrubber never blocks the user side.
    assign scrub_data_o = mem_q[scrub_addr_i];
    assign usr_data_o   = mem_q[usr_addr_i];

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl #(
    parameter int NUM_FRAMES  = 8,
    parameter int FRAME_WORDS = 16,
    parameter int WORD_W      = 32,
    parameter int CNT_W       = 8,
    localparam int FRAME_W    = $clog2(NUM_FRAMES),
    localparam int WORD_IDX_W = $clog2(FRAME_WORDS),
    localparam int ADDR_W     = FRAME_W + WORD_IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reload_i,
    input  logic [WORD_W-1:0]  rd_word_i,
    input  logic [WORD_W-1:0]  gold_word_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               we_o,
    output logic               init_done_o,
    output logic               repaired_o,
    output logic [FRAME_W-1:0] repaired_frame_o,
    output logic [CNT_W-1:0]   upset_count_o
);
    import scrub_pkg::*;

    localparam logic [CNT_W-1:0]      CNT_MAX    = '1;
    localparam logic [FRAME_W-1:0]    LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);
    localparam logic [WORD_IDX_W-1:0] LAST_WORD  = WORD_IDX_W'(FRAME_WORDS - 1);

    typedef struct packed {
        scrub_state_e            state;
        logic [FRAME_W-1:0]      fidx;
        logic [WORD_IDX_W-1:0]   widx;
        logic                    miss;
        logic                    rep;
        logic [FRAME_W-1:0]      rep_frame;
        logic [CNT_W-1:0]        cnt;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  we_d;
    logic  last_word, last_frame;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rep  = 1'b0;
        we_d       = 1'b0;
        last_word  = (ctl_q.widx == LAST_WORD);
        last_frame = (ctl_q.fidx == LAST_FRAME);

        unique case (ctl_q.state)
            ST_INIT: begin
                we_d       = 1'b1;
                ctl_d.widx = ctl_q.widx + 1'b1;
                if (last_word) begin
                    ctl_d.fidx = ctl_q.fidx + 1'b1;
                    if (last_frame) begin
                        ctl_d.state = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (rd_word_i != gold_word_i) begin
                    ctl_d.miss = 1'b1;
                end
                ctl_d.widx = ctl_q.widx + 1'b1;
                if (last_word) begin
                    ctl_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                we_d       = 1'b1;
                ctl_d.widx = ctl_q.widx + 1'b1;
                if (last_word) begin
                    ctl_d.state = ST_READ;
                    ctl_d.fidx  = ctl_q.fidx + 1'b1;
                    ctl_d.miss  = 1'b0;
                    if (ctl_q.miss) begin
                        ctl_d.rep       = 1'b1;
                        ctl_d.rep_frame = ctl_q.fidx;
                        ctl_d.cnt       = (ctl_q.cnt == CNT_MAX) ? ctl_q.cnt
                                                                 : ctl_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                ctl_d.state = ST_INIT;
            end
        endcase

        // Reload restarts the load but leaves the report state untouched.
        if (reload_i) begin
            ctl_d.state     = ST_INIT;
            ctl_d.fidx      = '0;
            ctl_d.widx      = '0;
            ctl_d.miss      = 1'b0;
            ctl_d.rep       = 1'b0;
            ctl_d.rep_frame = ctl_q.rep_frame;
            ctl_d.cnt       = ctl_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign addr_o           = {ctl_q.fidx, ctl_q.widx};
    assign we_o             = we_d;
    assign init_done_o      = (ctl_q.state != ST_INIT);
    assign repaired_o       = ctl_q.rep;
    assign repaired_frame_o = ctl_q.rep_frame;
    assign upset_count_o    = ctl_q.cnt;

endmodule

// File: rtl/cfg_scrubber.sv
module cfg_scrubber #(
    parameter int NUM_FRAMES  = 8,
    parameter int FRAME_WORDS = 16,
    parameter int WORD_W      = 32,
    parameter int CNT_W       = 8,
    localparam int DEPTH      = NUM_FRAMES * FRAME_WORDS,
    localparam int ADDR_W     = $clog2(DEPTH),
    localparam int FRAME_W    = $clog2(NUM_FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reload_i,
    input  logic               inj_en_i,
    input  logic [ADDR_W-1:0]  inj_addr_i,
    input  logic [WORD_W-1:0]  inj_mask_i,
    input  logic [ADDR_W-1:0]  usr_addr_i,
    output logic [WORD_W-1:0]  usr_data_o,
    output logic               init_done_o,
    output logic               repaired_o,
    output logic [FRAME_W-1:0] repaired_frame_o,
    output logic [CNT_W-1:0]   upset_count_o
);
    logic [ADDR_W-1:0] scrub_addr;
    logic [WORD_W-1:0] gold_word;
    logic [WORD_W-1:0] read_word;
    logic              scrub_we;

    scrub_golden #(
        .NUM_FRAMES (NUM_FRAMES),
        .FRAME_WORDS(FRAME_WORDS),
        .WORD_W     (WORD_W)
    ) u_golden (
        .addr_i(scrub_addr),
        .data_o(gold_word)
    );

    scrub_cfg_mem #(
        .DEPTH (DEPTH),
        .WORD_W(WORD_W)
    ) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (scrub_we),
        .waddr_i     (scrub_addr),
        .wdata_i     (gold_word),
        .inj_en_i    (inj_en_i),
        .inj_addr_i  (inj_addr_i),
        .inj_mask_i  (inj_mask_i),
        .scrub_addr_i(scrub_addr),
        .scrub_data_o(read_word),
        .usr_addr_i  (usr_addr_i),
        .usr_data_o  (usr_data_o)
    );

    scrub_ctrl #(
        .NUM_FRAMES (NUM_FRAMES),
        .FRAME_WORDS(FRAME_WORDS),
        .WORD_W     (WORD_W),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .reload_i        (reload_i),
        .rd_word_i       (read_word),
        .gold_word_i     (gold_word),
        .addr_o          (scrub_addr),
        .we_o            (scrub_we),
        .init_done_o     (init_done_o),
        .repaired_o      (repaired_o),
        .repaired_frame_o(repaired_frame_o),
        .upset_count_o   (upset_count_o)
    );

endmodule

// File: rtl/cfg_scrubber_chk.sv
module cfg_scrubber_chk #(
    parameter int NUM_FRAMES = 8,
    parameter int CNT_W      = 8,
    localparam int FRAME_W   = $clog2(NUM_FRAMES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reload_i,
    input logic               init_done_o,
    input logic               repaired_o,
    input logic [FRAME_W-1:0] repaired_frame_o,
    input logic [CNT_W-1:0]   upset_count_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    // R12
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repaired_o |=> !repaired_o);

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !repaired_o |-> $stable(upset_count_o));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repaired_o |-> ((upset_count_o == $past(upset_count_o) + 1'b1) ||
                        (($past(upset_count_o) == CNT_TOP) && (upset_count_o == CNT_TOP))));

    // R6
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !repaired_o |-> $stable(repaired_frame_o));

    // R2
    no_pulse_loading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done_o |-> !repaired_o);

    // R10
    reload_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> !init_done_o);

    // R10
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done_o) |-> $past(reload_i));

endmodule

bind cfg_scrubber cfg_scrubber_chk #(
    .NUM_FRAMES(NUM_FRAMES),
    .CNT_W     (CNT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reload_i        (reload_i),
    .init_done_o     (init_done_o),
    .repaired_o      (repaired_o),
    .repaired_frame_o(repaired_frame_o),
    .upset_count_o   (upset_count_o)
);

// File: tb/tb_cfg_scrubber.sv
module tb_cfg_scrubber;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 4;
    localparam int W      = 4;
    localparam int WORD_W = 16;
    localparam int CNT_W  = 3;
    localparam int ADDR_W = 4;
    localparam int PER    = 2 * W * N;
    localparam int CMAX   = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reload_i = 1'b0;
    logic              inj_en_i = 1'b0;
    logic [ADDR_W-1:0] inj_addr_i = '0;
    logic [WORD_W-1:0] inj_mask_i = '0;
    logic [ADDR_W-1:0] usr_addr_i = '0;
    logic [WORD_W-1:0] usr_data_o;
    logic              init_done_o;
    logic              repaired_o;
    logic [1:0]        repaired_frame_o;
    logic [CNT_W-1:0]  upset_count_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_scrubber #(.NUM_FRAMES(N), .FRAME_WORDS(W), .WORD_W(WORD_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .reload_i(reload_i), .inj_en_i(inj_en_i),
        .inj_addr_i(inj_addr_i), .inj_mask_i(inj_mask_i), .usr_addr_i(usr_addr_i),
        .usr_data_o(usr_data_o), .init_done_o(init_done_o), .repaired_o(repaired_o),
        .repaired_frame_o(repaired_frame_o), .upset_count_o(upset_count_o));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0;
    int fails = 0;
    int base  = 0;
    int exp_cnt = 0;
    bit prev_rep = 1'b0;

    typedef struct { int frame; int count; } exp_t;
    exp_t expq[$];

    function automatic logic [WORD_W-1:0] ref_word(input int f, input int w);
        return 16'hA5C3 ^ 16'(f * 'h0451) ^ 16'(w * 'h1203);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic read_word(input int f, input int w, output logic [WORD_W-1:0] v);
        usr_addr_i = ADDR_W'(f * W + w);
        #1;
        v = usr_data_o;
    endtask

    function automatic int pos_now();
        return (cyc - base) % PER;
    endfunction

    task automatic wait_pos(input int p);
        do @(negedge clk); while (pos_now() != p);
    endtask

    task automatic wait_init();
        do @(negedge clk); while (!init_done_o);
        base = cyc;
    endtask

    // Driver side of the scoreboard: expected pulse pushed before the flip.
    task automatic expect_pulse(input int f);
        exp_cnt = (exp_cnt == CMAX) ? CMAX : exp_cnt + 1;
        expq.push_back('{frame: f, count: exp_cnt});
    endtask

    task automatic inject(input int f, input int w, input logic [WORD_W-1:0] m);
        inj_en_i   = 1'b1;
        inj_addr_i = ADDR_W'(f * W + w);
        inj_mask_i = m;
        @(negedge clk);
        inj_en_i   = 1'b0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (expq.size() != 0 && n < 4 * PER) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        check(expq.size() == 0, req, "expected pulse missing", expq.size(), 0);
    endtask

    // Monitor side of the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (repaired_o) begin
                check(!prev_rep, "R12", "pulse wider than one cycle", 1, 0);
                if (expq.size() == 0) begin
                    check(1'b0, "R7", "unexpected pulse for frame", int'(repaired_frame_o), -1);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(int'(repaired_frame_o) == e.frame, "R4", "pulse frame",
                          int'(repaired_frame_o), e.frame);
                    check(int'(upset_count_o) == e.count, "R6", "count at pulse",
                          int'(upset_count_o), e.count);
                    check(pos_now() == ((e.frame + 1) * 2 * W) % PER, "R3",
                          "pulse position in sweep", pos_now(), ((e.frame + 1) * 2 * W) % PER);
                end
            end
            prev_rep = repaired_o;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] v;
        int c0;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(init_done_o == 1'b0, "R1", "init_done in reset", int'(init_done_o), 0);
        check(repaired_o == 1'b0, "R1", "repaired in reset", int'(repaired_o), 0);
        check(upset_count_o == '0, "R1", "count in reset", int'(upset_count_o), 0);
        check(repaired_frame_o == '0, "R1", "frame in reset", int'(repaired_frame_o), 0);

        rst_n = 1'b1;
        c0 = cyc;
        // R9: user port works during loading (word 0 written at first edge)
        @(negedge clk);
        read_word(0, 0, v);
        check(v == ref_word(0, 0), "R9", "user read during load", int'(v), int'(ref_word(0, 0)));
        wait_init();
        check(cyc - c0 == N * W, "R2", "load length", cyc - c0, N * W);
        for (int f = 0; f < N; f++) begin
            for (int w = 0; w < W; w++) begin
                read_word(f, w, v);
                check(v == ref_word(f, w), "R2", "golden after load", int'(v), int'(ref_word(f, w)));
            end
        end

        // R4 detection on a later visit, R11 flip visible at once
        wait_pos(3 * 2 * W);
        expect_pulse(1);
        inject(1, 2, 16'h0010);
        read_word(1, 2, v);
        check(v == (ref_word(1, 2) ^ 16'h0010), "R11", "flip applied", int'(v),
              int'(ref_word(1, 2) ^ 16'h0010));
        drain("R4");
        read_word(1, 2, v);
        check(v == ref_word(1, 2), "R4", "word restored", int'(v), int'(ref_word(1, 2)));

        // R5 two flips in one frame give one report
        wait_pos(0);
        expect_pulse(2);
        inject(2, 0, 16'h0001);
        inject(2, 3, 16'h8000);
        drain("R5");
        repeat (PER) @(negedge clk);
        check(int'(upset_count_o) == 2, "R5", "count after double flip", int'(upset_count_o), 2);
        read_word(2, 3, v);
        check(v == ref_word(2, 3), "R5", "second word restored", int'(v), int'(ref_word(2, 3)));

        // R7 flip between read and write of the same visit: silent repair
        wait_pos(3 * 2 * W + W - 1);
        inject(3, 0, 16'h0100);
        read_word(3, 0, v);
        check(v == (ref_word(3, 0) ^ 16'h0100), "R7", "flip present before write", int'(v),
              int'(ref_word(3, 0) ^ 16'h0100));
        @(negedge clk);
        read_word(3, 0, v);
        check(v == ref_word(3, 0), "R7", "restored by golden write", int'(v), int'(ref_word(3, 0)));
        repeat (PER) @(negedge clk);
        check(int'(upset_count_o) == 2, "R7", "count unchanged", int'(upset_count_o), 2);

        // R11 flip on the same edge as the write of that word
        wait_pos(W + 1);
        inject(0, 1, 16'h0F00);
        read_word(0, 1, v);
        check(v == ref_word(0, 1), "R11", "golden write wins", int'(v), int'(ref_word(0, 1)));
        repeat (PER) @(negedge clk);
        check(int'(upset_count_o) == 2, "R11", "count unchanged", int'(upset_count_o), 2);

        // R8 flip after the write: repaired within one sweep, reported next visit
        wait_pos(2 * 2 * W + W + 2);
        expect_pulse(2);
        inject(2, 1, 16'h0002);
        wait_pos(2 * 2 * W + W + 2);
        read_word(2, 1, v);
        check(v == ref_word(2, 1), "R8", "restored within one sweep", int'(v), int'(ref_word(2, 1)));
        drain("R8");

        // R6 saturation
        for (int k = 0; k < 6; k++) begin
            int f;
            f = k % N;
            wait_pos(((f + 2) % N) * 2 * W);
            expect_pulse(f);
            inject(f, k % W, WORD_W'(1) << k);
            drain("R6");
        end
        check(int'(upset_count_o) == CMAX, "R6", "saturated count", int'(upset_count_o), CMAX);

        // R10 reload: pending flip overwritten, count kept
        wait_pos(2 * W);
        inject(3, 2, 16'h4000);
        reload_i = 1'b1;
        c0 = cyc;
        @(negedge clk);
        reload_i = 1'b0;
        check(init_done_o == 1'b0, "R10", "init_done after reload", int'(init_done_o), 0);
        check(int'(upset_count_o) == CMAX, "R10", "count kept", int'(upset_count_o), CMAX);
        wait_init();
        check(cyc - (c0 + 1) == N * W, "R10", "reload length", cyc - (c0 + 1), N * W);
        read_word(3, 2, v);
        check(v == ref_word(3, 2), "R10", "flip overwritten", int'(v), int'(ref_word(3, 2)));
        repeat (PER + 2) @(negedge clk);
        check(int'(repaired_frame_o) == 1, "R10", "frame output kept", int'(repaired_frame_o), 1);
        check(int'(upset_count_o) == CMAX, "R10", "count after sweep", int'(upset_count_o), CMAX);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule